// File: doc/BRIEF.md
# Packed Pixel Palette Formatter

This block sits between the display memory read path and the panel data path of a passive-matrix panel controller. It takes 8- or 16-bit memory words, splits them into pixels of 1, 2, 4 or 8 bits, and looks each pixel up in three 16-entry, 4-bit colour tables (red, green and blue). The result is a 12-bit colour value per pixel, which allows 4096 possible colours. The block also derives the internal pixel-rate clock enable from the oscillator-rate clock. The divisor of that enable depends on both the pixel depth and the memory width.

A single word buffer holds the current memory word. When the buffer is empty, the block raises a fetch request, and the memory path answers with a valid word. Pixels then leave at one per clock enable. In monochrome operation, all three output lanes carry the green-table entry as a gray level. At depths below 4 bits, a 2-bit bank value for each table selects which part of that table is used. The 8-bit depth is a colour-only mode and needs the 16-bit memory; with the 8-bit memory it is refused. Palette entries are written through a simple write port.

Top module: `pix_palette_fmt`

## Requirements
- R1: `clk_en` is high once every D cycles and low otherwise. Counting rising edges k from the end of reset, it is high when k mod D = D-1. With `mem_wide`=0: D=2 for depth codes 0 and 1, and D=1 for code 2. With `mem_wide`=1: D=4 for codes 0 and 1, D=2 for code 2 and D=1 for code 3.
- R2: `fetch_req` is high exactly when the word buffer is empty and the configuration is legal. A word is taken only on an edge where both `fetch_req` and `mem_valid` are high. `mem_valid` at any other time has no effect.
- R3: Depth codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bits per pixel. Each accepted word yields 16/bpp pixels when `mem_wide`=1. When `mem_wide`=0 it yields 8/bpp pixels, and only `mem_data[7:0]` is used.
- R4: In 16-bit mode the pixels of `mem_data[7:0]` come out before those of `mem_data[15:8]`. Within a byte, pixels come out starting from the most significant bits.
- R5: A pixel is emitted on an edge where `clk_en` is high and the buffer holds pixels. It appears on the colour outputs with `pix_valid` high for exactly the following cycle.
- R6: When `color_en`=0 at depth codes 0 to 2, all three output lanes carry the green-table entry selected for the pixel.
- R7: When `color_en`=1 at depth codes 0 to 2, each lane reads its own table. The table index is {bank, 0, p} at 1 bpp, {bank, p[1:0]} at 2 bpp and p[3:0] at 4 bpp, where bank is that table's own bank input. Banks have no effect at 4 bpp.
- R8: At depth code 3 (always colour), red uses index {0, p[7:5]}, green uses {0, p[4:2]} and blue uses {00, p[1:0]}.
- R9: Depth code 3 with `mem_wide`=0 is illegal. In that configuration `fetch_req` and `pix_valid` stay low whatever `mem_valid` does.
- R10: A write with `pal_we`=1 stores `pal_val` at `pal_idx` in the table chosen by `pal_tbl` (0 red, 1 green, 2 blue). `pal_tbl`=3 has no effect. A write affects pixels emitted on later edges.
- R11: Reset sets every table entry i to the value i and empties the buffer. It also drives `pix_valid` and the colour outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| depth_sel | input | 2 | Pixel depth code: 0=1, 1=2, 2=4, 3=8 bits |
| mem_wide | input | 1 | 1 = 16-bit display memory, 0 = 8-bit |
| color_en | input | 1 | 1 = colour lookup, 0 = gray through green table |
| red_bank | input | 2 | Red table bank at depths below 4 bits |
| grn_bank | input | 2 | Green table bank at depths below 4 bits |
| blu_bank | input | 2 | Blue table bank at depths below 4 bits |
| pal_we | input | 1 | Palette write strobe |
| pal_tbl | input | 2 | Table to write: 0 red, 1 green, 2 blue |
| pal_idx | input | 4 | Entry to write |
| pal_val | input | 4 | Value to write |
| mem_data | input | 16 | Display memory word |
| mem_valid | input | 1 | Memory word is valid |
| fetch_req | output | 1 | Word buffer empty, request the next word |
| clk_en | output | 1 | Pixel-rate clock enable |
| pix_valid | output | 1 | Colour outputs carry a new pixel this cycle |
| pix_r | output | 4 | Red lane |
| pix_g | output | 4 | Green lane |
| pix_b | output | 4 | Blue lane |

## Verification
The hardest condition to reach is the point where fetch requests interleave with the clock-enable phase. The last pixel of a word, the following empty-buffer cycle and the next load must fall on different enable phases for each divisor. The bench holds `mem_valid` high all the time and changes `mem_data` only when it sees a request. Any word taken outside a request would therefore show up as a wrong pixel or a wrong word count. This is swept over every combination of depth, memory width and colour flag, with different banks and a reprogrammed palette each time. The illegal combination is held with `mem_valid` active to show that nothing is accepted.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

    localparam int CW     = 4;
    localparam int PAL_N  = 16;
    localparam int IDX_W  = $clog2(PAL_N);
    localparam int MEM_W  = 16;
    localparam int BYTE_W = 8;
    localparam int LANES  = 3;
    localparam int REM_W  = $clog2(MEM_W + 1);
    localparam int DIV_W  = 3;

    typedef enum logic [1:0] {
        DEP_1 = 2'd0,
        DEP_2 = 2'd1,
        DEP_4 = 2'd2,
        DEP_8 = 2'd3
    } depth_e;

    typedef struct packed {
        logic [CW-1:0] r;
        logic [CW-1:0] g;
        logic [CW-1:0] b;
    } rgb_t;

    function automatic logic cfg_legal(depth_e d, logic wide);
        return !(d == DEP_8 && !wide);
    endfunction

    function automatic logic [DIV_W-1:0] div_of(depth_e d, logic wide);
        logic [DIV_W-1:0] v;
        case (d)
            DEP_1, DEP_2: v = wide ? 3'd4 : 3'd2;
            DEP_4:        v = wide ? 3'd2 : 3'd1;
            default:      v = 3'd1;
        endcase
        return v;
    endfunction

    function automatic logic [3:0] bpp_of(depth_e d);
        return 4'd1 << d;
    endfunction

    function automatic logic [IDX_W-1:0] lane_index(int lane, depth_e d,
                                                    logic [1:0] bank,
                                                    logic [BYTE_W-1:0] c);
        logic [IDX_W-1:0] v;
        case (d)
            DEP_1: v = {bank, 1'b0, c[0]};
            DEP_2: v = {bank, c[1:0]};
            DEP_4: v = c[3:0];
            default: begin
                if (lane == 0)      v = {1'b0, c[7:5]};
                else if (lane == 1) v = {1'b0, c[4:2]};
                else                v = {2'b00, c[1:0]};
            end
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ppf_clkdiv.sv
module ppf_clkdiv
    import ppf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  depth_e     depth,
    input  logic       wide,
    output logic       clk_en
);
    logic [DIV_W-2:0] cnt;
    logic [DIV_W-1:0] div_m1;

    assign div_m1 = div_of(depth, wide) - 3'd1;
    assign clk_en = ({1'b0, cnt} == div_m1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if ({1'b0, cnt} >= div_m1)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ppf_unpack.sv
module ppf_unpack
    import ppf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  depth_e            depth,
    input  logic              wide,
    input  logic              clk_en,
    input  logic [MEM_W-1:0]  mem_data,
    input  logic              mem_valid,
    output logic              fetch_req,
    output logic              emit,
    output logic [BYTE_W-1:0] code
);
    logic [MEM_W-1:0] sh;
    logic [REM_W-1:0] rem;
    logic             legal;
    logic [REM_W-1:0] per_word;

    assign legal     = cfg_legal(depth, wide);
    assign fetch_req = legal && (rem == '0);
    assign emit      = legal && clk_en && (rem != '0);
    assign per_word  = (wide ? REM_W'(MEM_W) : REM_W'(BYTE_W)) >> depth;

    always_comb begin
        case (depth)
            DEP_1:   code = {7'b0, sh[MEM_W-1]};
            DEP_2:   code = {6'b0, sh[MEM_W-1 -: 2]};
            DEP_4:   code = {4'b0, sh[MEM_W-1 -: 4]};
            default: code = sh[MEM_W-1 -: BYTE_W];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !legal) begin
            sh  <= '0;
            rem <= '0;
        end else if (fetch_req && mem_valid) begin
            sh  <= wide ? {mem_data[BYTE_W-1:0], mem_data[MEM_W-1:BYTE_W]}
                        : {mem_data[BYTE_W-1:0], {BYTE_W{1'b0}}};
            rem <= per_word;
        end else if (emit) begin
            sh  <= sh << bpp_of(depth);
            rem <= rem - 1'b1;
        end
    end
endmodule

// File: rtl/ppf_palette.sv
module ppf_palette
    import ppf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  depth_e                depth,
    input  logic                  color_en,
    input  logic [LANES-1:0][1:0] banks,
    input  logic                  pal_we,
    input  logic [1:0]            pal_tbl,
    input  logic [IDX_W-1:0]      pal_idx,
    input  logic [CW-1:0]         pal_val,
    input  logic                  emit,
    input  logic [BYTE_W-1:0]     code,
    output logic                  pix_valid,
    output rgb_t                  pix
);
    logic [LANES-1:0][CW-1:0] lane_val;
    rgb_t                     mapped;

    for (genvar t = 0; t < LANES; t++) begin : g_lane
        logic [CW-1:0]    tbl [PAL_N];
        logic [IDX_W-1:0] idx;

        assign idx         = lane_index(t, depth, banks[t], code);
        assign lane_val[t] = tbl[idx];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < PAL_N; i++)
                    tbl[i] <= CW'(i);
            end else if (pal_we && pal_tbl == 2'(t)) begin
                tbl[pal_idx] <= pal_val;
            end
        end
    end

    always_comb begin
        if (color_en || depth == DEP_8)
            mapped = '{r: lane_val[0], g: lane_val[1], b: lane_val[2]};
        else
            mapped = '{r: lane_val[1], g: lane_val[1], b: lane_val[1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_valid <= 1'b0;
            pix       <= '0;
        end else begin
            pix_valid <= emit;
            if (emit)
                pix <= mapped;
        end
    end
endmodule

// File: rtl/pix_palette_fmt.sv
module pix_palette_fmt
    import ppf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  depth_sel,
    input  logic        mem_wide,
    input  logic        color_en,
    input  logic [1:0]  red_bank,
    input  logic [1:0]  grn_bank,
    input  logic [1:0]  blu_bank,
    input  logic        pal_we,
    input  logic [1:0]  pal_tbl,
    input  logic [3:0]  pal_idx,
    input  logic [3:0]  pal_val,
    input  logic [15:0] mem_data,
    input  logic        mem_valid,
    output logic        fetch_req,
    output logic        clk_en,
    output logic        pix_valid,
    output logic [3:0]  pix_r,
    output logic [3:0]  pix_g,
    output logic [3:0]  pix_b
);
    depth_e                  depth;
    logic                    emit;
    logic [BYTE_W-1:0]       code;
    logic [LANES-1:0][1:0]   banks;
    rgb_t                    pix;

    assign depth = depth_e'(depth_sel);
    assign banks = {blu_bank, grn_bank, red_bank};

    ppf_clkdiv u_div (
        .clk    (clk),
        .rst    (rst),
        .depth  (depth),
        .wide   (mem_wide),
        .clk_en (clk_en)
    );

    ppf_unpack u_unp (
        .clk       (clk),
        .rst       (rst),
        .depth     (depth),
        .wide      (mem_wide),
        .clk_en    (clk_en),
        .mem_data  (mem_data),
        .mem_valid (mem_valid),
        .fetch_req (fetch_req),
        .emit      (emit),
        .code      (code)
    );

    ppf_palette u_pal (
        .clk       (clk),
        .rst       (rst),
        .depth     (depth),
        .color_en  (color_en),
        .banks     (banks),
        .pal_we    (pal_we),
        .pal_tbl   (pal_tbl),
        .pal_idx   (pal_idx),
        .pal_val   (pal_val),
        .emit      (emit),
        .code      (code),
        .pix_valid (pix_valid),
        .pix       (pix)
    );

    assign pix_r = pix.r;
    assign pix_g = pix.g;
    assign pix_b = pix.b;
endmodule

// File: rtl/ppf_checker.sv
module ppf_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] depth_sel,
    input logic       mem_wide,
    input logic       mem_valid,
    input logic       fetch_req,
    input logic       clk_en,
    input logic       pix_valid
);
    logic illegal;
    logic slow_cfg;
    assign illegal  = (depth_sel == 2'd3) && !mem_wide;
    assign slow_cfg = (mem_wide && depth_sel != 2'd3) || (!mem_wide && depth_sel < 2'd2);

    // R9
    illegal_no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !fetch_req);

    // R9
    illegal_no_pixel_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |=> !pix_valid);

    // R5
    pixel_after_enable_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> $past(clk_en));

    // R1
    full_rate_chk: assert property (@(posedge clk) disable iff (rst)
        (depth_sel == 2'd3 && mem_wide && $past(depth_sel) == 2'd3 && $past(mem_wide))
        |-> clk_en);

    // R1
    enable_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (slow_cfg && clk_en) |=> (!clk_en || !slow_cfg));

    // R2
    one_word_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && mem_valid) |=> !fetch_req);
endmodule

bind pix_palette_fmt ppf_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .depth_sel (depth_sel),
    .mem_wide  (mem_wide),
    .mem_valid (mem_valid),
    .fetch_req (fetch_req),
    .clk_en    (clk_en),
    .pix_valid (pix_valid)
);

// File: tb/sim_pix_palette_fmt.sv
module sim_pix_palette_fmt;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  depth_sel = '0;
    logic        mem_wide = 1'b0, color_en = 1'b0;
    logic [1:0]  red_bank = '0, grn_bank = '0, blu_bank = '0;
    logic        pal_we = 1'b0;
    logic [1:0]  pal_tbl = '0;
    logic [3:0]  pal_idx = '0, pal_val = '0;
    logic [15:0] mem_data = '0;
    logic        mem_valid = 1'b0;
    logic        fetch_req, clk_en, pix_valid;
    logic [3:0]  pix_r, pix_g, pix_b;

    int tests = 0, fails = 0;
    int ek;
    int mt [3][16];
    bit done = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) ek <= 0;
        else     ek <= ek + 1;
    end

    pix_palette_fmt u0 (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int word_of(int k, int cfg);
        return (k * 40503 + cfg * 4660 + 23100) & 16'hFFFF;
    endfunction

    function automatic int div_m(int d, int w);
        if (d < 2) return w ? 4 : 2;
        if (d == 2) return w ? 2 : 1;
        return 1;
    endfunction

    function automatic int idx_m(int lane, int d, int bank, int p);
        if (d == 0) return bank * 4 + (p & 1);
        if (d == 1) return bank * 4 + (p & 3);
        if (d == 2) return p & 15;
        if (lane == 0) return (p >> 5) & 7;
        if (lane == 1) return (p >> 2) & 7;
        return p & 3;
    endfunction

    task automatic do_reset();
        rst = 1'b1; mem_valid = 1'b0; pal_we = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int t = 0; t < 3; t++)
            for (int i = 0; i < 16; i++) mt[t][i] = i;
    endtask

    task automatic pal_write(input int t, input int i, input int v);
        pal_we = 1'b1; pal_tbl = 2'(t); pal_idx = 4'(i); pal_val = 4'(v);
        @(negedge clk);
        pal_we = 1'b0;
        if (t < 3) mt[t][i] = v;
    endtask

    task automatic run_cfg(input int d, input int w, input int c, input bit prog);
        int cfg = d * 4 + w * 2 + c;
        int bpp = 1 << d;
        int ppw = (w ? 16 : 8) / bpp;
        int target = 3 * ppw;
        int n = 0, k = 0;
        int banks [3];
        bit en_bad = 0, timing_bad = 0, prev_en = 0;
        string tag;
        depth_sel = 2'(d); mem_wide = w[0]; color_en = c[0];
        banks[0] = (d + w) & 3; banks[1] = (c + 1 + d) & 3; banks[2] = (3 * d + w + c) & 3;
        red_bank = 2'(banks[0]); grn_bank = 2'(banks[1]); blu_bank = 2'(banks[2]);
        do_reset();
        if (prog) begin
            for (int t = 0; t < 3; t++)
                for (int i = 0; i < 16; i++)
                    pal_write(t, i, (i * (2 * t + 3) + cfg + t) & 15);
            // R10: table code 3 must leave every table unchanged
            for (int i = 0; i < 16; i++) pal_write(3, i, 15 - i);
        end
        tag = (d == 3) ? "R8" : (c == 0 ? "R6" : (d < 2 ? "R7" : "R4"));
        mem_valid = 1'b1;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            // R1: enable phase against edges since reset
            if (clk_en !== (((ek % div_m(d, w)) == div_m(d, w) - 1) ? 1'b1 : 1'b0)) en_bad = 1;
            if (pix_valid) begin
                int wv = word_of(n / ppw, cfg);
                int o = (n % ppw) * bpp;
                int by = (o >= 8) ? (wv >> 8) & 255 : wv & 255;
                int p = (by >> (8 - bpp - (o % 8))) & ((1 << bpp) - 1);
                int er, eg, eb;
                if (!prev_en) timing_bad = 1;
                er = mt[0][idx_m(0, d, banks[0], p)];
                eg = mt[1][idx_m(1, d, banks[1], p)];
                eb = mt[2][idx_m(2, d, banks[2], p)];
                if (c == 0 && d != 3) begin er = eg; eb = eg; end
                chk({pix_r, pix_g, pix_b} == 12'((er << 8) | (eg << 4) | eb), tag,
                    {pix_r, pix_g, pix_b}, (er << 8) | (eg << 4) | eb);
                n++;
                if (n == target) break;
            end
            prev_en = clk_en;
            // R2: data changes only once a request has been seen
            mem_data = 16'(word_of(k, cfg));
            if (fetch_req) k++;
            @(negedge clk);
        end
        mem_valid = 1'b0;
        chk(n == target, "R5 pixel count", n, target);
        chk(k == 3, "R3 words used", k, 3);
        chk(!en_bad, "R1 enable phase", en_bad, 0);
        chk(!timing_bad, "R5 pixel follows enable", timing_bad, 0);
    endtask

    initial begin
        #1000000;
        fails++;
        tests++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R11: reset state at the ports
        chk(pix_valid == 1'b0, "R11 pix_valid", pix_valid, 0);
        chk({pix_r, pix_g, pix_b} == 12'h0, "R11 colour", {pix_r, pix_g, pix_b}, 0);
        chk(fetch_req == 1'b1, "R11 fetch_req", fetch_req, 1);
        // R11: identity palette after reset, 4 bpp colour
        run_cfg(2, 1, 1, 0);
        for (int d = 0; d < 4; d++)
            for (int w = 0; w < 2; w++)
                for (int c = 0; c < 2; c++)
                    if (!(d == 3 && w == 0)) run_cfg(d, w, c, 1);
        // R9: illegal combination ignores mem_valid
        begin
            bit bad = 0;
            depth_sel = 2'd3; mem_wide = 1'b0;
            do_reset();
            mem_valid = 1'b1; mem_data = 16'hA5C3;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (fetch_req || pix_valid) bad = 1;
            end
            mem_valid = 1'b0;
            chk(!bad, "R9 illegal idle", bad, 0);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule